// File: doc/BRIEF.md
# Split-Frame Doorbell Mailbox

This unit passes 32-bit doorbell flag words from one agent (the sender) to another (the receiver) over up to three one-way channels. Each side has its own register frame on its own simple memory-mapped port: address, write strobe, write data, read strobe and read data. Every channel keeps one shared status word. The sender raises flag bits in that word and the receiver clears them. A per-channel receiver interrupt stays high while any flag in the word is up. The sender knows a doorbell has been consumed once its own read of the status word returns zero.

Before ringing, the sender must raise a wake request and wait for the ready indication. Ready follows the request after a fixed number of cycles, which models the receiver's wake latency. While ready is low, doorbell writes are dropped. The sender frame also holds a read-only register that reports how many channels are built.

Top module: `dbell_mbox_top`

## Requirements
- R1: A sender write to channel offset 0xC (channel window base = channel × 0x20) ORs the write data into that channel's status word, provided wake-ready is 1 in that cycle.
- R2: A receiver write to channel offset 0x8 clears every status bit for which the write data holds a 1 and leaves the other bits unchanged.
- R3: Offset 0x0 of a channel window returns that channel's status word in both frames. Read data appears on the read-data port in the cycle after the read strobe, and it is zero in any cycle after a cycle with no read strobe.
- R4: The interrupt bit for channel i is 1 exactly while status word i is nonzero. It follows the status word from the clock edge that changes the word.
- R5: A sender read of address 0xF80 returns the number of built channels (NUM_CH, 1 to 3).
- R6: A sender write to 0xF88 stores bit 0 as the wake request. The request reads back at 0xF88 and drives `wake_req`. Ready reads as bit 0 of 0xF8C. Ready becomes 1 WAKE_LAT clock edges after the edge that stores a 1 in the request, and becomes 0 at the edge that stores a 0.
- R7: A sender write to offset 0xC while ready is 0 leaves the status word unchanged.
- R8: Sender offset 0xC and receiver offset 0x8 read as zero. Other window offsets, channels at or above NUM_CH, and any address in the wrong frame read as zero and ignore writes. The receiver frame cannot reach 0xF80, 0xF88 or 0xF8C.
- R9: When a set write and a clear write hit the same channel in the same cycle, the new word is (old & ~clear) | set.
- R10: Reset clears every status word, the wake request and ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| snd_addr | input | ADDR_W | Sender frame byte address |
| snd_wr | input | 1 | Sender write strobe |
| snd_wdata | input | DATA_W | Sender write data |
| snd_rd | input | 1 | Sender read strobe |
| snd_rdata | output | DATA_W | Sender read data, one cycle after the strobe |
| rcv_addr | input | ADDR_W | Receiver frame byte address |
| rcv_wr | input | 1 | Receiver write strobe |
| rcv_wdata | input | DATA_W | Receiver write data |
| rcv_rd | input | 1 | Receiver read strobe |
| rcv_rdata | output | DATA_W | Receiver read data, one cycle after the strobe |
| rcv_irq | output | NUM_CH | Per-channel interrupt, high while the word is nonzero |
| wake_req | output | 1 | Wake request towards the receiver |

## Verification
Writes take effect at the clock edge that samples the strobe. The status word and the interrupt therefore change at that edge, and a read issued in the next cycle returns the new value. Read data is due one edge after the read strobe. The bench drives the strobes at falling edges and samples the read data at the next falling edge, so every sample falls half a cycle after the edge that produced it. The wake latency is measured by back-to-back reads of the ready register: the k-th read after the request write reflects k−1 edges since the request, so it must read 1 exactly when k−1 ≥ WAKE_LAT.

// File: rtl/dbm_pkg.sv
package dbm_pkg;
   localparam int unsigned MAX_CH    = 3;
   localparam int unsigned WIN_SHIFT = 5;           // 0x20-byte channel windows
   localparam logic [4:0]  OFS_STAT  = 5'h00;
   localparam logic [4:0]  OFS_CLR   = 5'h08;
   localparam logic [4:0]  OFS_SET   = 5'h0C;
   localparam logic [11:0] ADR_CAP   = 12'hF80;
   localparam logic [11:0] ADR_REQ   = 12'hF88;
   localparam logic [11:0] ADR_RDY   = 12'hF8C;
endpackage

// File: rtl/dbm_win_dec.sv
module dbm_win_dec #(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned NUM_CH = 3
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [NUM_CH-1:0] ch_hit,
   output logic [4:0]        ofs
);
   localparam int unsigned SEL_W = ADDR_W - dbm_pkg::WIN_SHIFT;

   assign ofs = addr[dbm_pkg::WIN_SHIFT-1:0];

   for (genvar i = 0; i < NUM_CH; i++) begin : g_hit
      assign ch_hit[i] = (addr[ADDR_W-1:dbm_pkg::WIN_SHIFT] == SEL_W'(i));
   end
endmodule

// File: rtl/dbm_stat_word.sv
module dbm_stat_word #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] set_mask,
   input  logic [DATA_W-1:0] clr_mask,
   output logic [DATA_W-1:0] word,
   output logic              irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word <= '0;
      else        word <= (word & ~clr_mask) | set_mask;
   end

   assign irq = |word;
endmodule

// File: rtl/dbm_wake.sv
module dbm_wake #(
   parameter int unsigned WAKE_LAT = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_wr,
   input  logic req_val,
   output logic req,
   output logic rdy
);
   localparam int unsigned CW = $clog2(WAKE_LAT + 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      req <= 1'b0;
      else if (req_wr) req <= req_val;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt <= '0;
      else if (!req)                   cnt <= '0;
      else if (cnt != CW'(WAKE_LAT))   cnt <= cnt + 1'b1;
   end

   assign rdy = req && (cnt == CW'(WAKE_LAT));
endmodule

// File: rtl/dbell_mbox_top.sv
module dbell_mbox_top #(
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned NUM_CH   = 3,
   parameter int unsigned WAKE_LAT = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] snd_addr,
   input  logic              snd_wr,
   input  logic [DATA_W-1:0] snd_wdata,
   input  logic              snd_rd,
   output logic [DATA_W-1:0] snd_rdata,
   input  logic [ADDR_W-1:0] rcv_addr,
   input  logic              rcv_wr,
   input  logic [DATA_W-1:0] rcv_wdata,
   input  logic              rcv_rd,
   output logic [DATA_W-1:0] rcv_rdata,
   output logic [NUM_CH-1:0] rcv_irq,
   output logic              wake_req
);
   import dbm_pkg::*;

   if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_bad_nch
      $error("dbell_mbox_top: NUM_CH must be 1..3");
   end
   if (ADDR_W < 12) begin : g_bad_aw
      $error("dbell_mbox_top: ADDR_W must be at least 12");
   end
   if (WAKE_LAT < 1) begin : g_bad_lat
      $error("dbell_mbox_top: WAKE_LAT must be at least 1");
   end
   if (DATA_W < 2) begin : g_bad_dw
      $error("dbell_mbox_top: DATA_W must be at least 2");
   end

   localparam logic [ADDR_W-1:0] A_CAP = ADDR_W'(ADR_CAP);
   localparam logic [ADDR_W-1:0] A_REQ = ADDR_W'(ADR_REQ);
   localparam logic [ADDR_W-1:0] A_RDY = ADDR_W'(ADR_RDY);

   logic [NUM_CH-1:0]             snd_hit, rcv_hit;
   logic [4:0]                    snd_ofs, rcv_ofs;
   logic [NUM_CH-1:0][DATA_W-1:0] stat_q;
   logic                          acc_req, acc_rdy;
   logic [DATA_W-1:0]             snd_rv, rcv_rv;

   dbm_win_dec #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_snd_dec (
      .addr(snd_addr), .ch_hit(snd_hit), .ofs(snd_ofs));
   dbm_win_dec #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_rcv_dec (
      .addr(rcv_addr), .ch_hit(rcv_hit), .ofs(rcv_ofs));

   dbm_wake #(.WAKE_LAT(WAKE_LAT)) u_wake (
      .clk    (clk),
      .rst_n  (rst_n),
      .req_wr (snd_wr && (snd_addr == A_REQ)),
      .req_val(snd_wdata[0]),
      .req    (acc_req),
      .rdy    (acc_rdy));

   assign wake_req = acc_req;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic [DATA_W-1:0] set_m, clr_m;
      assign set_m = (snd_wr && acc_rdy && snd_hit[i] && snd_ofs == OFS_SET)
                     ? snd_wdata : '0;
      assign clr_m = (rcv_wr && rcv_hit[i] && rcv_ofs == OFS_CLR)
                     ? rcv_wdata : '0;
      dbm_stat_word #(.DATA_W(DATA_W)) u_word (
         .clk(clk), .rst_n(rst_n), .set_mask(set_m), .clr_mask(clr_m),
         .word(stat_q[i]), .irq(rcv_irq[i]));
   end

   always_comb begin
      snd_rv = '0;
      rcv_rv = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (snd_hit[i] && snd_ofs == OFS_STAT) snd_rv = stat_q[i];
         if (rcv_hit[i] && rcv_ofs == OFS_STAT) rcv_rv = stat_q[i];
      end
      if (snd_addr == A_CAP) snd_rv = DATA_W'(NUM_CH);
      if (snd_addr == A_REQ) snd_rv = {{(DATA_W-1){1'b0}}, acc_req};
      if (snd_addr == A_RDY) snd_rv = {{(DATA_W-1){1'b0}}, acc_rdy};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snd_rdata <= '0;
         rcv_rdata <= '0;
      end else begin
         snd_rdata <= snd_rd ? snd_rv : '0;
         rcv_rdata <= rcv_rd ? rcv_rv : '0;
      end
   end
endmodule

// File: rtl/dbm_mbox_chk.sv
module dbm_mbox_chk #(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned NUM_CH = 3
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          snd_rd,
   input logic [ADDR_W-1:0]             snd_addr,
   input logic [DATA_W-1:0]             snd_rdata,
   input logic                          rcv_rd,
   input logic [ADDR_W-1:0]             rcv_addr,
   input logic [DATA_W-1:0]             rcv_rdata,
   input logic                          req,
   input logic                          rdy,
   input logic [NUM_CH-1:0][DATA_W-1:0] stat
);
   localparam logic [ADDR_W-1:0] A_CAP = ADDR_W'(12'hF80);
   localparam logic [ADDR_W-1:0] A_REQ = ADDR_W'(12'hF88);
   localparam logic [ADDR_W-1:0] A_RDY = ADDR_W'(12'hF8C);

   p_cap_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (snd_rd && snd_addr == A_CAP) |=> (snd_rdata == DATA_W'(NUM_CH)));

   p_req_readback_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (snd_rd && snd_addr == A_REQ) |=> (snd_rdata == DATA_W'($past(req))));

   p_ready_after_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rdy) |-> $past(req));

   p_rcv_no_access_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rcv_rd && (rcv_addr == A_CAP || rcv_addr == A_REQ || rcv_addr == A_RDY))
      |=> (rcv_rdata == '0));

   for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
      p_no_set_asleep_r7: assert property (@(posedge clk) disable iff (!rst_n)
         !rdy |=> ((stat[i] & ~$past(stat[i])) == '0));
   end
endmodule

bind dbell_mbox_top dbm_mbox_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CH(NUM_CH)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .snd_rd(snd_rd), .snd_addr(snd_addr), .snd_rdata(snd_rdata),
   .rcv_rd(rcv_rd), .rcv_addr(rcv_addr), .rcv_rdata(rcv_rdata),
   .req(acc_req), .rdy(acc_rdy), .stat(stat_q)
);

// File: tb/dbell_mbox_top_tb_top.sv
module dbell_mbox_top_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int AW  = 12;
   localparam int DW  = 32;
   localparam int NCH = 3;
   localparam int LAT = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [AW-1:0] s_addr = '0, r_addr = '0;
   logic s_wr = 0, s_rd = 0, r_wr = 0, r_rd = 0;
   logic [DW-1:0] s_wd = '0, r_wd = '0;
   logic [DW-1:0] s_rdata, r_rdata, s1_rdata, r1_rdata;
   logic [NCH-1:0] irq;
   logic [0:0] irq1;
   logic wreq, wreq1;
   logic [AW-1:0] s1_addr = '0;
   logic s1_rd = 0;

   int total = 0, bad = 0;
   logic [DW-1:0] model [NCH];
   logic [DW-1:0] got;

   always #(CLK_PERIOD/2) clk = ~clk;

   dbell_mbox_top #(.ADDR_W(AW), .DATA_W(DW), .NUM_CH(NCH), .WAKE_LAT(LAT)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .snd_addr(s_addr), .snd_wr(s_wr), .snd_wdata(s_wd), .snd_rd(s_rd), .snd_rdata(s_rdata),
      .rcv_addr(r_addr), .rcv_wr(r_wr), .rcv_wdata(r_wd), .rcv_rd(r_rd), .rcv_rdata(r_rdata),
      .rcv_irq(irq), .wake_req(wreq));

   dbell_mbox_top #(.ADDR_W(AW), .DATA_W(DW), .NUM_CH(1), .WAKE_LAT(1)) dut1_i (
      .clk(clk), .rst_n(rst_n),
      .snd_addr(s1_addr), .snd_wr(1'b0), .snd_wdata('0), .snd_rd(s1_rd), .snd_rdata(s1_rdata),
      .rcv_addr('0), .rcv_wr(1'b0), .rcv_wdata('0), .rcv_rd(1'b0), .rcv_rdata(r1_rdata),
      .rcv_irq(irq1), .wake_req(wreq1));

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   // All tasks start and end at a falling edge.
   task automatic snd_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      s_addr = a; s_wd = d; s_wr = 1;
      @(negedge clk);
      s_wr = 0;
   endtask

   task automatic rcv_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      r_addr = a; r_wd = d; r_wr = 1;
      @(negedge clk);
      r_wr = 0;
   endtask

   task automatic both_write(input int ch, input logic [DW-1:0] sm, input logic [DW-1:0] cm);
      s_addr = AW'(ch*32 + 12); s_wd = sm; s_wr = 1;
      r_addr = AW'(ch*32 + 8);  r_wd = cm; r_wr = 1;
      @(negedge clk);
      s_wr = 0; r_wr = 0;
   endtask

   task automatic snd_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
      s_addr = a; s_rd = 1;
      @(negedge clk);
      s_rd = 0;
      d = s_rdata;
   endtask

   task automatic rcv_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
      r_addr = a; r_rd = 1;
      @(negedge clk);
      r_rd = 0;
      d = r_rdata;
   endtask

   task automatic check_all(input string req);
      for (int c = 0; c < NCH; c++) begin
         snd_read(AW'(c*32), got); chk({req, " snd stat"}, got, model[c]);
         rcv_read(AW'(c*32), got); chk({req, " rcv stat"}, got, model[c]);
         chk({req, " R4 irq"}, DW'(irq[c]), DW'(model[c] != 0));
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      for (int c = 0; c < NCH; c++) model[c] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R10: reset state
      check_all("R10");
      chk("R10 wake_req", DW'(wreq), 0);
      snd_read(12'hF8C, got); chk("R10 ready", got, 0);
      // idle read data is zero (R3)
      chk("R3 idle rdata", s_rdata, 0);

      // R5: capability on both configurations
      snd_read(12'hF80, got); chk("R5 cap", got, NCH);
      s1_addr = 12'hF80; s1_rd = 1; @(negedge clk); s1_rd = 0;
      chk("R5 cap one-channel", s1_rdata, 1);

      // R7: doorbell while asleep is dropped
      snd_write(12'h00C, 32'h0000_00FF);
      check_all("R7");

      // R6: wake latency, k-th read reflects k-1 edges after the request edge
      snd_write(12'hF88, 32'h1);
      for (int k = 1; k <= LAT + 2; k++) begin
         snd_read(12'hF8C, got);
         chk("R6 ready latency", got, DW'((k - 1) >= LAT));
      end
      chk("R6 wake_req", DW'(wreq), 1);
      snd_read(12'hF88, got); chk("R6 req readback", got, 1);

      // R1/R3/R4: set and OR
      snd_write(12'h00C, 32'h0000_00A5); model[0] |= 32'h0000_00A5;
      check_all("R1");
      snd_write(12'h00C, 32'h0000_0100); model[0] |= 32'h0000_0100;
      check_all("R1 or");

      // R8: write-only registers read zero
      snd_read(12'h00C, got); chk("R8 set reads zero", got, 0);
      rcv_read(12'h008, got); chk("R8 clr reads zero", got, 0);

      // R2: clear
      rcv_write(12'h008, 32'h0000_0005); model[0] &= ~32'h0000_0005;
      check_all("R2 partial");
      rcv_write(12'h008, 32'hFFFF_FFFF); model[0] = '0;
      check_all("R2 full");

      // R1/R2 sweep over every channel and several patterns
      for (int c = 0; c < NCH; c++) begin
         for (int p = 0; p < 4; p++) begin
            logic [DW-1:0] pat;
            pat = (32'h1 << (c*7 + p*3)) | (32'h8000_0000 >> p);
            snd_write(AW'(c*32 + 12), pat); model[c] |= pat;
            check_all("R1 sweep");
         end
         rcv_write(AW'(c*32 + 8), 32'h8000_0000); model[c] &= ~32'h8000_0000;
         check_all("R2 sweep");
      end

      // R9: simultaneous set and clear on channel 1
      both_write(1, 32'h0000_00F0, 32'hFFFF_00FF);
      model[1] = (model[1] & ~32'hFFFF_00FF) | 32'h0000_00F0;
      check_all("R9");

      // R8: unimplemented channel/offsets and wrong frame
      snd_write(12'h06C, 32'hFFFF_FFFF);
      snd_read(12'h060, got); chk("R8 chan3 stat", got, 0);
      snd_write(12'h004, 32'h0000_0F00);
      snd_write(12'h010, 32'h0000_0F00);
      snd_write(12'h028, 32'hFFFF_FFFF);
      rcv_write(12'h04C, 32'h0000_0F00);
      snd_read(12'h004, got); chk("R8 hole reads zero", got, 0);
      check_all("R8 ignored writes");
      rcv_write(12'hF88, 32'h0);
      snd_read(12'hF8C, got); chk("R8 rcv cannot drop req", got, 1);
      rcv_read(12'hF8C, got); chk("R8 rcv ready hidden", got, 0);
      rcv_read(12'hF80, got); chk("R8 rcv cap hidden", got, 0);

      // R6/R7: withdraw request
      snd_write(12'hF88, 32'h0);
      chk("R6 wake_req low", DW'(wreq), 0);
      snd_read(12'hF8C, got); chk("R6 ready drops", got, 0);
      snd_write(12'h02C, 32'h0000_0E00);
      check_all("R7 after withdraw");

      // R10: reset in mid-flight
      rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
      for (int c = 0; c < NCH; c++) model[c] = '0;
      check_all("R10 mid reset");
      snd_read(12'hF88, got); chk("R10 req cleared", got, 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule